// File: doc/BRIEF.md
# Synchronous Bus Command Snooper with In-Flight Bit Override

This block listens to a two-wire synchronous link. The link clock idles high. The sender changes data after a falling edge and the receiver samples it on the next rising edge, most significant bit first. Each byte ends with one extra falling edge, the acknowledge.

The snooper tracks the stream as command bytes, each followed by a number of argument bytes. A constant per-opcode lookup gives that number, so the snooper stays aligned to byte boundaries without any help from the bus.

Normally the snooper only listens. When the upper seven bits of a command equal the pattern that covers opcodes 0x12 and 0x13, it pulls the open-drain data line low for the final bit, so the receiver always reads opcode 0x12.

A per-byte inactivity timer abandons any transfer that stalls and returns the snooper to waiting for an idle clock. Both link inputs are resynchronised to a fast system clock. The hold time of the override and the stall limit are counted in system-clock cycles.

Top module: `cmd_snoop`

## Requirements
- R1: After a synchronous reset, `dat_pull` and `in_cmd` are low. Once the link clock has been seen high, `awake` goes low.
- R2: While `awake` is low, the first low level of the link clock starts a command byte. `in_cmd` (and `awake`) stay high until the falling edge that acknowledges that byte, and then `in_cmd` falls.
- R3: Command bits are captured on link-clock rising edges, most significant first. The opcode that selects the argument count is the 8-bit value assembled this way.
- R4: If bits 7..1 of a command equal binary 0001001 (opcode 0x12 or 0x13), `dat_pull` rises after the falling edge that precedes bit 0. It stays high for HOLD_CYCLES system cycles after the rising edge that samples bit 0, so the line reads 0 at that edge. It is then released before the acknowledge.
- R5: For every other opcode, and for every argument byte, `dat_pull` stays low and the sampled bit is the one driven by the sender.
- R6: Argument counts by opcode (hex). 7 for 80. 5 for 69, 6A, C9, CA, E8, EA. 4 for 86. 3 for 30, 33, 81, 87, 93, 95, C2. 2 for 31, 34, 40..4F, 91, B0, B2. 1 for 10..2F, 32, 50..5F, 6B..6F, 90, 94, A0, B1, B3, C0, C1, C4, C5, C7, CF, E0, E4. 0 for every other opcode.
- R7: Each argument byte has a leading falling edge, 8 rising edges and an acknowledge falling edge. During an argument byte `in_cmd` stays low and `awake` stays high. After the last argument is acknowledged, the snooper goes back to waiting, and `awake` falls once the clock is high.
- R8: If TIMEOUT_CYCLES system cycles pass between the first clock activity of a byte and its acknowledge, the transfer is abandoned. `dat_pull` and `in_cmd` drop, and the next idle-then-low clock starts a fresh command.
- R9: The timer does not run between bytes. A long high clock after an argument acknowledge does not abandon the remaining arguments.
- R10: If the acknowledge falling edge arrives while the bit-0 override is still being held, `dat_pull` is released and that edge counts as the acknowledge.
- R11: After an abandoned transfer, `awake` stays high while the link clock remains low. It falls only after the clock returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the link clock |
| rst | input | 1 | Synchronous active-high reset |
| link_clk | input | 1 | Link clock line, idles high |
| link_dat | input | 1 | Link data line as seen on the wire |
| dat_pull | output | 1 | Enables the open-drain pull-down of the data line |
| awake | output | 1 | Low only while idle and waiting for a command |
| in_cmd | output | 1 | High from command start until its acknowledge |

## Verification
On every cycle, the assertions check several rules:
- The pull-down is on only inside a command.
- The pull-down rises only after a matched prefix.
- A timer expiry clears both the pull-down and the command flag on the next cycle.
- A command begins only from the idle state.
- Each argument acknowledge lowers the remaining count by exactly one.

Only the bench scenarios can show the end-to-end behaviour. Its opcode sweep exercises the whole argument table through framing, seen as which later bytes raise `in_cmd`. It checks the bit value the receiver actually sees, the release time of the override and its early cut by a quick acknowledge. It also checks that stalls inside a byte abandon the transfer while stalls between bytes do not.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  localparam int ARGC_W = 3;

  typedef enum logic [3:0] {
    ST_WAIT_HIGH,
    ST_IDLE,
    ST_CMD_BITS,
    ST_CMD_FORCE,
    ST_CMD_DRIVE,
    ST_CMD_HOLD,
    ST_CMD_ACK,
    ST_ARG_GAP,
    ST_ARG_LEAD,
    ST_ARG_BITS,
    ST_ARG_ACK
  } snoop_state_e;

  // Upper seven opcode bits that select the bit-0 override.
  function automatic logic forced_prefix(input logic [6:0] hi7);
    return hi7 == 7'b0001001;
  endfunction

  // Number of argument bytes following each opcode.
  function automatic logic [ARGC_W-1:0] arg_count(input logic [7:0] op);
    logic [ARGC_W-1:0] n;
    case (op) inside
      8'h80:                                       n = 3'd7;
      8'h69, 8'h6A, 8'hC9, 8'hCA, 8'hE8, 8'hEA:    n = 3'd5;
      8'h86:                                       n = 3'd4;
      8'h30, 8'h33, 8'h81, 8'h87, 8'h93, 8'h95,
      8'hC2:                                       n = 3'd3;
      [8'h40:8'h4F], 8'h31, 8'h34, 8'h91, 8'hB0,
      8'hB2:                                       n = 3'd2;
      [8'h10:8'h2F], [8'h50:8'h5F], [8'h6B:8'h6F],
      8'h32, 8'h90, 8'h94, 8'hA0, 8'hB1, 8'hB3,
      8'hC0, 8'hC1, 8'hC4, 8'hC5, 8'hC7, 8'hCF,
      8'hE0, 8'hE4:                                n = 3'd1;
      default:                                     n = 3'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], pin};
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/snoop_timer.sv
module snoop_timer #(
  parameter int LIMIT = 175000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/snoop_fsm.sv
module snoop_fsm
  import snoop_pkg::*;
#(
  parameter int HOLD_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk,
  input  logic              bdat,
  input  logic              expired,
  output logic              run_timer,
  output logic              dat_pull,
  output logic              awake,
  output logic              in_cmd,
  output logic              armed,
  output logic              arg_ack_ev,
  output logic [ARGC_W-1:0] arg_left
);
  localparam int BYTE_BITS = 8;
  localparam int BIT_W = $clog2(BYTE_BITS);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_BITS - 1);
  localparam logic [BIT_W-1:0] BIT_PRE  = BIT_W'(BYTE_BITS - 2);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  snoop_state_e      state, nxt;
  logic              bclk_d;
  logic [7:0]        shreg, sh_n, sh_new;
  logic [BIT_W-1:0]  bit_cnt, bit_n;
  logic [ARGC_W-1:0] args_n, argc_cmd;
  logic [HW-1:0]     hold_cnt, hold_n;
  logic              rise, fall;

  assign rise     = bclk & ~bclk_d;
  assign fall     = ~bclk & bclk_d;
  assign sh_new   = {shreg[6:0], bdat};
  assign argc_cmd = arg_count(shreg);

  always_comb begin
    nxt        = state;
    sh_n       = shreg;
    bit_n      = bit_cnt;
    args_n     = arg_left;
    hold_n     = hold_cnt;
    arg_ack_ev = 1'b0;
    case (state)
      ST_WAIT_HIGH: if (bclk) nxt = ST_IDLE;
      ST_IDLE: if (!bclk) begin
        nxt   = ST_CMD_BITS;
        sh_n  = '0;
        bit_n = '0;
      end
      ST_CMD_BITS: if (rise) begin
        sh_n  = sh_new;
        bit_n = bit_cnt + 1'b1;
        if (bit_cnt == BIT_PRE && forced_prefix(sh_new[6:0])) nxt = ST_CMD_FORCE;
        else if (bit_cnt == BIT_LAST)                         nxt = ST_CMD_ACK;
      end
      ST_CMD_FORCE: if (fall) nxt = ST_CMD_DRIVE;
      ST_CMD_DRIVE: if (rise) begin
        sh_n   = {shreg[6:0], 1'b0};
        hold_n = '0;
        nxt    = ST_CMD_HOLD;
      end
      ST_CMD_HOLD: begin
        if (fall) begin
          args_n = argc_cmd;
          nxt    = (argc_cmd == '0) ? ST_WAIT_HIGH : ST_ARG_GAP;
        end else if (hold_cnt == HOLD_LAST) begin
          nxt = ST_CMD_ACK;
        end else begin
          hold_n = hold_cnt + 1'b1;
        end
      end
      ST_CMD_ACK: if (fall) begin
        args_n = argc_cmd;
        nxt    = (argc_cmd == '0) ? ST_WAIT_HIGH : ST_ARG_GAP;
      end
      ST_ARG_GAP:  if (rise) nxt = ST_ARG_LEAD;
      ST_ARG_LEAD: if (fall) begin
        nxt   = ST_ARG_BITS;
        bit_n = '0;
      end
      ST_ARG_BITS: if (rise) begin
        bit_n = bit_cnt + 1'b1;
        if (bit_cnt == BIT_LAST) nxt = ST_ARG_ACK;
      end
      ST_ARG_ACK: if (fall) begin
        arg_ack_ev = 1'b1;
        args_n     = arg_left - 1'b1;
        nxt        = (arg_left == ARGC_W'(1)) ? ST_WAIT_HIGH : ST_ARG_GAP;
      end
      default: nxt = ST_WAIT_HIGH;
    endcase
    if (expired) nxt = ST_WAIT_HIGH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_WAIT_HIGH;
      bclk_d   <= 1'b1;
      shreg    <= '0;
      bit_cnt  <= '0;
      arg_left <= '0;
      hold_cnt <= '0;
      dat_pull <= 1'b0;
      in_cmd   <= 1'b0;
      awake    <= 1'b1;
    end else begin
      state    <= nxt;
      bclk_d   <= bclk;
      shreg    <= sh_n;
      bit_cnt  <= bit_n;
      arg_left <= args_n;
      hold_cnt <= hold_n;
      dat_pull <= (nxt == ST_CMD_DRIVE) || (nxt == ST_CMD_HOLD);
      in_cmd   <= (nxt inside {ST_CMD_BITS, ST_CMD_FORCE, ST_CMD_DRIVE,
                               ST_CMD_HOLD, ST_CMD_ACK});
      awake    <= (nxt != ST_IDLE);
    end
  end

  assign run_timer = state inside {ST_CMD_BITS, ST_CMD_FORCE, ST_CMD_DRIVE,
                                   ST_CMD_HOLD, ST_CMD_ACK, ST_ARG_BITS, ST_ARG_ACK};
  assign armed     = (state == ST_CMD_FORCE);
endmodule

// File: rtl/cmd_snoop.sv
module cmd_snoop
  import snoop_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int HOLD_CYCLES    = 250,
  parameter int TIMEOUT_CYCLES = 175000
) (
  input  logic clk,
  input  logic rst,
  input  logic link_clk,
  input  logic link_dat,
  output logic dat_pull,
  output logic awake,
  output logic in_cmd
);
  logic              bclk_s, bdat_s;
  logic              tmr_run, tmr_expired;
  logic              force_armed, arg_ack_ev;
  logic [ARGC_W-1:0] arg_left;

  snoop_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_clk (
    .clk(clk), .rst(rst), .pin(link_clk), .level(bclk_s));

  snoop_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_dat (
    .clk(clk), .rst(rst), .pin(link_dat), .level(bdat_s));

  snoop_timer #(.LIMIT(TIMEOUT_CYCLES)) i_timer (
    .clk(clk), .rst(rst), .run(tmr_run), .expired(tmr_expired));

  snoop_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) i_fsm (
    .clk(clk), .rst(rst), .bclk(bclk_s), .bdat(bdat_s),
    .expired(tmr_expired), .run_timer(tmr_run),
    .dat_pull(dat_pull), .awake(awake), .in_cmd(in_cmd),
    .armed(force_armed), .arg_ack_ev(arg_ack_ev), .arg_left(arg_left));
endmodule

// File: rtl/snoop_checker.sv
module snoop_checker (
  input logic       clk,
  input logic       rst,
  input logic       dat_pull,
  input logic       awake,
  input logic       in_cmd,
  input logic       tmr_expired,
  input logic       force_armed,
  input logic       arg_ack_ev,
  input logic [2:0] arg_left
);
  assert_pull_in_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    dat_pull |-> in_cmd);

  assert_pull_after_match_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dat_pull) |-> $past(force_armed));

  assert_expire_release_R8: assert property (@(posedge clk) disable iff (rst)
    tmr_expired |=> (!dat_pull && !in_cmd));

  assert_cmd_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_cmd) |-> $past(!awake));

  assert_cmd_awake_R2: assert property (@(posedge clk) disable iff (rst)
    in_cmd |-> awake);

  assert_arg_decrement_R7: assert property (@(posedge clk) disable iff (rst)
    arg_ack_ev |=> (arg_left + 3'd1 == $past(arg_left)));
endmodule

bind cmd_snoop snoop_checker i_snoop_checker (
  .clk(clk), .rst(rst), .dat_pull(dat_pull), .awake(awake), .in_cmd(in_cmd),
  .tmr_expired(tmr_expired), .force_armed(force_armed),
  .arg_ack_ev(arg_ack_ev), .arg_left(arg_left));

// File: tb/test_cmd_snoop.sv
module test_cmd_snoop;
  localparam int H    = 12;
  localparam int HOLD = 6;
  localparam int TMO  = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lclk = 1'b1;
  logic drv = 1'b1;
  logic line;
  logic dat_pull, awake, in_cmd;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  assign line = drv & ~dat_pull;

  cmd_snoop #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .TIMEOUT_CYCLES(TMO)) i_cmd_snoop (
    .clk(clk), .rst(rst), .link_clk(lclk), .link_dat(line),
    .dat_pull(dat_pull), .awake(awake), .in_cmd(in_cmd));

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_args(input int op);
    if (op >= 'h10 && op <= 'h2f) return 1;
    if (op >= 'h40 && op <= 'h4f) return 2;
    if (op >= 'h50 && op <= 'h5f) return 1;
    if (op >= 'h6b && op <= 'h6f) return 1;
    case (op)
      'h80: return 7;
      'h86: return 4;
      'h69, 'h6a, 'hc9, 'hca, 'he8, 'hea: return 5;
      'h30, 'h33, 'h81, 'h87, 'h93, 'h95, 'hc2: return 3;
      'h31, 'h34, 'h91, 'hb0, 'hb2: return 2;
      'h32, 'h90, 'h94, 'ha0, 'hb1, 'hb3, 'hc0, 'hc1, 'hc4, 'hc5,
      'hc7, 'hcf, 'he0, 'he4: return 1;
      default: return 0;
    endcase
  endfunction

  // One byte on the link; ends with the clock high for H cycles.
  task automatic send_byte(input logic [7:0] v, input bit is_cmd, input bit early);
    bit forced;
    forced = is_cmd && (v[7:1] == 7'b0001001);
    for (int i = 7; i >= 0; i--) begin
      lclk = 1'b0;
      drv  = v[i];
      wait_cyc(H);
      if (i == 7) begin
        chk(in_cmd, is_cmd, is_cmd ? "R2 in_cmd at command" : "R7 in_cmd low in argument");
        chk(awake, 1, "R2 awake during byte");
      end
      lclk = 1'b1;
      if (i == 0) begin
        wait_cyc(1);
        chk(line, forced ? 0 : int'(v[0]), forced ? "R4 bit0 forced" : "R5 bit0 passes");
        if (early) begin
          wait_cyc(2);
          chk(dat_pull, 1, "R10 pull before early ack");
        end else begin
          wait_cyc(4);
          chk(dat_pull, forced, forced ? "R4 pull held" : "R5 no pull");
          wait_cyc(H - 6);
          chk(dat_pull, 0, "R4 pull released before ack");
        end
      end else begin
        wait_cyc(H);
      end
    end
    lclk = 1'b0;
    drv  = 1'b1;
    wait_cyc(H);
    chk(in_cmd, 0, "R2 in_cmd low after ack");
    chk(dat_pull, 0, early ? "R10 pull released by ack" : "R5 pull low at ack");
    lclk = 1'b1;
    wait_cyc(H);
  endtask

  task automatic run_op(input int op);
    int n;
    n = exp_args(op);
    send_byte(8'(op), 1'b1, 1'b0);
    chk(awake, (n != 0) ? 1 : 0, "R6 framing after command");
    for (int k = 0; k < n; k++) begin
      send_byte((k == 0) ? 8'h13 : 8'(op ^ k), 1'b0, 1'b0);
      chk(awake, (k + 1 < n) ? 1 : 0, "R7 awake after argument");
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    chk(dat_pull, 0, "R1 pull after reset");
    chk(in_cmd, 0, "R1 in_cmd after reset");
    wait_cyc(8);
    chk(awake, 0, "R1 awake low when idle");

    // R3 R6 sweep of every opcode; R4 on 0x12/0x13, R5 elsewhere
    for (int op = 0; op < 256; op++) run_op(op);

    // R8: stall inside an argument byte with the clock high
    send_byte(8'h30, 1'b1, 1'b0);
    send_byte(8'h55, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      lclk = 1'b0; wait_cyc(H); lclk = 1'b1; wait_cyc(H);
    end
    wait_cyc(TMO + 50);
    chk(awake, 0, "R8 back to idle after stall");
    chk(in_cmd, 0, "R8 in_cmd low after stall");
    send_byte(8'h00, 1'b1, 1'b0);
    chk(awake, 0, "R8 resync command framed");

    // R9: long gap between arguments is not a timeout
    send_byte(8'h31, 1'b1, 1'b0);
    send_byte(8'hA5, 1'b0, 1'b0);
    wait_cyc(TMO + 200);
    chk(awake, 1, "R9 still awaiting argument");
    send_byte(8'h5A, 1'b0, 1'b0);
    chk(awake, 0, "R9 idle after last argument");

    // R11: stall with the clock held low inside a command
    lclk = 1'b0;
    wait_cyc(TMO + 50);
    chk(in_cmd, 0, "R11 in_cmd dropped on stall");
    chk(awake, 1, "R11 awake while clock low");
    chk(dat_pull, 0, "R11 pull low");
    lclk = 1'b1;
    wait_cyc(H);
    chk(awake, 0, "R11 idle once clock high");
    send_byte(8'h00, 1'b1, 1'b0);
    chk(awake, 0, "R11 next command accepted");

    // R10: acknowledge arrives during the hold
    send_byte(8'h13, 1'b1, 1'b1);
    chk(awake, 1, "R10 ack counted, argument pending");
    send_byte(8'h12, 1'b0, 1'b0);
    chk(awake, 0, "R10 framing kept");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule